// File: doc/BRIEF.md
# Two-Section Presettable Counter

This block is a 4-bit counter split into two sections, each with its own count strobe. The low section is a single bit that divides by two. The high section is three bits wide. It divides by five in the decade variant and by eight in the binary variant, and a parameter picks the variant. Each section advances when its strobe falls.

An active-low clear forces every output bit to zero. An active-low load input copies a 4-bit data word to the outputs. Both act at the outputs in the same cycle, whatever the strobes are doing. While load stays low the outputs follow the data word, so the block can be used as a 4-bit latch with load as the strobe.

The block runs on one system clock. The two section strobes are ordinary inputs, and the block samples them to find their falling edges. Outputs can be fed back into the strobes from outside, which gives BCD, plain binary or bi-quinary counting chains.

Top module: `dual_section_counter`

## Requirements
- R1: When `rst_n` is low at a rising `clk` edge, the stored count becomes 0. With `clr_n` and `ld_n` high, `q` reads 0 after that edge.
- R2: A falling edge of `tick_lo` is seen when `tick_lo` is sampled 1 at one rising `clk` edge and 0 at the next. With `clr_n` and `ld_n` high, `q[0]` inverts at the second of those edges.
- R3: The high section is `q[3:1]`, with `q[3]` as its most significant bit. On a detected falling edge of `tick_hi`, a value below the last state goes up by one. The last state is 4 in the decade variant and 7 in the binary variant.
- R4: On a detected falling edge of `tick_hi`, a value at or above the last state goes to 0. In the decade variant this includes the loaded values 5, 6 and 7.
- R5: While `clr_n` is low, `q` is 0 in the same cycle. This holds even when `ld_n` is low. The stored count is cleared, so `q` stays 0 after release until the next counted edge.
- R6: While `ld_n` is low and `clr_n` is high, `q` equals `din` in the same cycle and follows every change of `din`. Load takes priority over counting.
- R7: With `clr_n` and `ld_n` high and no falling strobe edge, `q` does not change.
- R8: Strobe falls that happen while clear or load is held are never counted. After release, counting starts from the held value at the next falling edge. `din` must be stable for one `clk` cycle before `ld_n` rises.
- R9: A rising edge on either strobe has no effect on `q`.
- R10: Feeding `q[0]` to `tick_hi` gives a 0..9 count in the decade variant and a 0..15 count in the binary variant. In the decade variant, feeding `q[3]` to `tick_lo` and clocking `tick_hi` makes `q[0]` rise on the 5th input pulse and fall on the 10th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_lo | input | 1 | Count strobe of the one-bit section; counts when it falls |
| tick_hi | input | 1 | Count strobe of the three-bit section; counts when it falls |
| clr_n | input | 1 | Active-low clear; overrides load and counting |
| ld_n | input | 1 | Active-low load/latch enable |
| din | input | 4 | Data copied to the outputs while loading |
| q | output | 4 | Count value; q[0] is the low section, q[3:1] the high section |

## Verification
A corrupted high-section state shows up at the next falling edge of `tick_hi`. The step or the wrap to zero lands on the wrong value, and in a BCD chain the decade no longer closes after ten pulses. A stuck low-section bit shows at the very next falling edge of `tick_lo`. A strobe-history register that keeps a stale value makes the block count an edge on the release of load or clear. That shows at the ports one cycle after release, as a value different from the one that was loaded. In the cascaded wirings, one wrong step spreads into the other section within two clock cycles.

// File: rtl/dual_section_counter_pkg.sv
`timescale 1ns/1ps
// Package: shared variant type and high-section step helper.
// Assumes the high section is at most 8 bits wide.
package dual_section_counter_pkg;

    typedef enum logic {
        SEC_DECADE = 1'b0,
        SEC_BINARY = 1'b1
    } sec_variant_e;

    // Last state of the high section for a given variant and width.
    function automatic int unsigned sec_last(sec_variant_e v, int unsigned w);
        return (v == SEC_DECADE) ? 4 : ((1 << w) - 1);
    endfunction

endpackage

// File: rtl/strobe_fall_detect.sv
`timescale 1ns/1ps
// strobe_fall_detect: samples a strobe on every rising clk edge and flags
// a falling edge when the previous sample was 1 and the current input is 0.
// Assumes the strobe is quiet around the rising clk edge.
// The history keeps updating during clear and load, so edges seen in that
// time are used up and never counted later.
module strobe_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic prev_q;

    // Purpose: remember the strobe level seen at the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe;
    end

    // Purpose: flag a high-to-low transition between samples.
    always_comb fall = prev_q & ~strobe;

endmodule

// File: rtl/low_section.sv
`timescale 1ns/1ps
// low_section: the one-bit divide-by-two stage. Priority is reset, then
// clear, then load, then toggle on a detected fall.
// Assumes the fall input lasts exactly one clk cycle per edge.
module low_section (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic ld_n,
    input  logic load_bit,
    input  logic fall,
    output logic state
);
    // Purpose: stored toggle bit with clear and load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= 1'b0;
        else if (!clr_n) state <= 1'b0;
        else if (!ld_n)  state <= load_bit;
        else if (fall)   state <= ~state;
    end
endmodule

// File: rtl/high_section.sv
`timescale 1ns/1ps
// high_section: the multi-bit stage. It divides by five (decade variant)
// or by 2**W (binary variant). Any value at or above the last state
// returns to 0 on the next counted edge.
// Assumes W is at least 3 for the decade variant.
module high_section
    import dual_section_counter_pkg::*;
#(
    parameter sec_variant_e VARIANT = SEC_DECADE,
    parameter int unsigned  W       = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic [W-1:0] load_val,
    input  logic         fall,
    output logic [W-1:0] state
);
    localparam int unsigned  LAST_I = sec_last(VARIANT, W);
    localparam logic [W-1:0] LAST   = LAST_I[W-1:0];

    logic [W-1:0] next_val;

    // Pick the step rule: natural wrap for full binary, compare otherwise.
    generate
        if (VARIANT == SEC_BINARY) begin : g_bin
            // Purpose: plain increment that wraps at 2**W.
            always_comb next_val = state + 1'b1;
        end else begin : g_dec
            // Purpose: increment below the last state, else return to 0.
            always_comb next_val = (state >= LAST) ? '0 : state + 1'b1;
        end
    endgenerate

    // Purpose: stored section value with clear and load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= '0;
        else if (!clr_n) state <= '0;
        else if (!ld_n)  state <= load_val;
        else if (fall)   state <= next_val;
    end
endmodule

// File: rtl/dual_section_counter.sv
`timescale 1ns/1ps
// dual_section_counter: two separately strobed count sections with a
// clear and a load/latch that act at the outputs in the same cycle.
// Clear overrides load, and load overrides counting.
// Assumes the strobes and din are stable around rising clk edges, and
// that din is held one cycle before ld_n rises.
module dual_section_counter
    import dual_section_counter_pkg::*;
#(
    parameter sec_variant_e VARIANT = SEC_DECADE,
    parameter int unsigned  UP_W    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_lo,
    input  logic          tick_hi,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic [UP_W:0] din,
    output logic [UP_W:0] q
);
    localparam int unsigned TOT_W = UP_W + 1;

    logic            fall_lo;
    logic            fall_hi;
    logic            lo_state;
    logic [UP_W-1:0] hi_state;

    strobe_fall_detect u_fall_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (tick_lo),
        .fall   (fall_lo)
    );

    strobe_fall_detect u_fall_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (tick_hi),
        .fall   (fall_hi)
    );

    low_section u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .load_bit (din[0]),
        .fall     (fall_lo),
        .state    (lo_state)
    );

    high_section #(
        .VARIANT (VARIANT),
        .W       (UP_W)
    ) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .load_val (din[UP_W:1]),
        .fall     (fall_hi),
        .state    (hi_state)
    );

    // Purpose: same-cycle output override: clear, then load, then count.
    always_comb begin
        if (!clr_n)     q = '0;
        else if (!ld_n) q = din;
        else            q = {hi_state, lo_state};
    end

    logic unused_w;
    always_comb unused_w = (TOT_W == 0);

endmodule

// File: rtl/dual_section_counter_chk.sv
`timescale 1ns/1ps
// dual_section_counter_chk: temporal checks on the counter's ports and on
// the fall flags that the detectors drive. Bound into every instance.
module dual_section_counter_chk
    import dual_section_counter_pkg::*;
#(
    parameter sec_variant_e VARIANT = SEC_DECADE,
    parameter int unsigned  UP_W    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_n,
    input logic          ld_n,
    input logic          fall_lo,
    input logic          fall_hi,
    input logic [UP_W:0] din,
    input logic [UP_W:0] q
);
    localparam int unsigned     LAST_I = sec_last(VARIANT, UP_W);
    localparam logic [UP_W-1:0] LAST   = LAST_I[UP_W-1:0];

    a_r2_low_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && fall_lo) |=> ((clr_n && ld_n) |-> (q[0] != $past(q[0]))));

    a_r3_upper_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && fall_hi && (q[UP_W:1] < LAST))
        |=> ((clr_n && ld_n) |-> (q[UP_W:1] == $past(q[UP_W:1]) + 1'b1)));

    a_r4_upper_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && fall_hi && (q[UP_W:1] >= LAST))
        |=> ((clr_n && ld_n) |-> (q[UP_W:1] == '0)));

    a_r5_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n) |=> ((clr_n && ld_n) |-> (q == '0)));

    a_r6_load_held: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n) |=> ((clr_n && ld_n) |-> (q == $past(din))));

    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !fall_lo && !fall_hi) |=> ((clr_n && ld_n) |-> $stable(q)));

endmodule

bind dual_section_counter dual_section_counter_chk #(
    .VARIANT (VARIANT),
    .UP_W    (UP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .fall_lo (fall_lo),
    .fall_hi (fall_hi),
    .din     (din),
    .q       (q)
);

// File: tb/test_dual_section_counter.sv
`timescale 1ns/1ps
// Bench: drives a decade and a binary instance with the same stimulus
// under three wirings (0 independent, 1 low-to-high chain, 2 high-to-low
// chain) and compares both with pulse-level models.
module test_dual_section_counter;
    import dual_section_counter_pkg::*;

    localparam real CYC = 4.0;

    logic clk = 1'b0;
    logic rst_n, clr_n, ld_n, t_lo, t_hi;
    logic [3:0] din;
    logic [1:0] mode;
    logic [3:0] q_dec, q_bin;
    logic [3:0] m_dec, m_bin;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CYC / 2.0) clk = ~clk;

    wire dec_tlo = (mode == 2'd2) ? q_dec[3] : t_lo;
    wire dec_thi = (mode == 2'd1) ? q_dec[0] : t_hi;
    wire bin_tlo = (mode == 2'd2) ? q_bin[3] : t_lo;
    wire bin_thi = (mode == 2'd1) ? q_bin[0] : t_hi;

    dual_section_counter #(.VARIANT(SEC_DECADE), .UP_W(3)) i_dual_section_counter (
        .clk(clk), .rst_n(rst_n), .tick_lo(dec_tlo), .tick_hi(dec_thi),
        .clr_n(clr_n), .ld_n(ld_n), .din(din), .q(q_dec));

    dual_section_counter #(.VARIANT(SEC_BINARY), .UP_W(3)) i_dual_section_counter_bin (
        .clk(clk), .rst_n(rst_n), .tick_lo(bin_tlo), .tick_hi(bin_thi),
        .clr_n(clr_n), .ld_n(ld_n), .din(din), .q(q_bin));

    function automatic logic [2:0] up_next(logic [2:0] v, bit dec);
        if (dec) return (v >= 3'd4) ? 3'd0 : v + 3'd1;
        return v + 3'd1;
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_both(input string tag);
        chk({tag, " decade"}, q_dec, m_dec);
        chk({tag, " binary"}, q_bin, m_bin);
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic step_lo(inout logic [3:0] m, input bit dec);
        logic old;
        old = m[0];
        m[0] = ~m[0];
        if (mode == 2'd1 && old) m[3:1] = up_next(m[3:1], dec);
    endtask

    task automatic step_hi(inout logic [3:0] m, input bit dec);
        logic old;
        old = m[3];
        m[3:1] = up_next(m[3:1], dec);
        if (mode == 2'd2 && old && !m[3]) m[0] = ~m[0];
    endtask

    // R2/R9 (and R10 under mode 1): one full pulse on the low strobe.
    task automatic pulse_lo();
        @(negedge clk); t_lo = 1'b1;
        waitn(2);
        chk_both("R9 rise on tick_lo ignored");
        t_lo = 1'b0;
        waitn(3);
        step_lo(m_dec, 1'b1);
        step_lo(m_bin, 1'b0);
        chk_both("R2/R10 low strobe count");
    endtask

    // R3/R4/R9 (and R10 under mode 2): one full pulse on the high strobe.
    task automatic pulse_hi();
        @(negedge clk); t_hi = 1'b1;
        waitn(2);
        chk_both("R9 rise on tick_hi ignored");
        t_hi = 1'b0;
        waitn(3);
        step_hi(m_dec, 1'b1);
        step_hi(m_bin, 1'b0);
        chk_both("R3/R4 high strobe count");
    endtask

    // R6/R8: load a value, wiggle din while held, then settle and release.
    task automatic do_load(input logic [3:0] v);
        logic [3:0] other;
        @(negedge clk); din = ~v; ld_n = 1'b0;
        #1; other = ~v;
        chk("R6 load same cycle decade", q_dec, other);
        chk("R6 load same cycle binary", q_bin, other);
        @(negedge clk); din = v;
        #1;
        chk("R6 latch follows din decade", q_dec, v);
        chk("R6 latch follows din binary", q_bin, v);
        waitn(2);
        ld_n = 1'b1;
        m_dec = v;
        m_bin = v;
        waitn(2);
        chk_both("R8 value kept after load release");
    endtask

    // R5: clear, together with load for priority, then release.
    task automatic do_clear();
        @(negedge clk); clr_n = 1'b0; ld_n = 1'b0; din = 4'hF;
        #1;
        chk("R5 clear beats load decade", q_dec, 4'h0);
        chk("R5 clear beats load binary", q_bin, 4'h0);
        @(negedge clk); ld_n = 1'b1;
        waitn(1);
        clr_n = 1'b1;
        m_dec = 4'h0;
        m_bin = 4'h0;
        waitn(2);
        chk_both("R5 clear persists after release");
    endtask

    task automatic set_mode(input logic [1:0] md);
        @(negedge clk); ld_n = 1'b0; din = 4'h0; t_lo = 1'b0; t_hi = 1'b0;
        waitn(1);
        mode = md;
        waitn(2);
        ld_n = 1'b1;
        m_dec = 4'h0;
        m_bin = 4'h0;
        waitn(2);
        chk_both("R8 mode switch settles at zero");
    endtask

    initial begin
        #(CYC * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0196));
        rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b1; t_lo = 1'b0; t_hi = 1'b0;
        din = 4'h0; mode = 2'd0;
        m_dec = 4'h0; m_bin = 4'h0;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        chk_both("R1 reset state");

        // R7: quiet inputs hold the value.
        do_load(4'hB);
        waitn(8);
        chk_both("R7 hold without strobe edges");

        // R1: reset again from a nonzero value.
        @(negedge clk); rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        m_dec = 4'h0; m_bin = 4'h0;
        waitn(1);
        chk_both("R1 reset clears loaded value");

        // R3/R4: high section up to and past its last state.
        for (int i = 0; i < 9; i++) pulse_hi();
        // R4: loaded values 5..7 return to zero in the decade variant.
        for (int v = 5; v < 8; v++) begin
            do_load(4'(v << 1));
            pulse_hi();
            chk("R4 decade out-of-range high value", {1'b0, q_dec[3:1]}, 4'h0);
        end
        for (int i = 0; i < 3; i++) pulse_lo();

        // R8: strobe falls while load is held are not counted.
        @(negedge clk); ld_n = 1'b0; din = 4'h3;
        @(negedge clk); t_lo = 1'b1; t_hi = 1'b1;
        waitn(2);
        t_lo = 1'b0; t_hi = 1'b0;
        waitn(3);
        ld_n = 1'b1;
        m_dec = 4'h3; m_bin = 4'h3;
        waitn(3);
        chk_both("R8 no edge counted across load");
        pulse_lo();

        // R8: same while clear is held.
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); t_hi = 1'b1;
        waitn(2);
        t_hi = 1'b0;
        waitn(2);
        clr_n = 1'b1;
        m_dec = 4'h0; m_bin = 4'h0;
        waitn(3);
        chk_both("R8 no edge counted across clear");
        do_clear();

        // R10: low-to-high chain.
        set_mode(2'd1);
        for (int i = 0; i < 10; i++) pulse_lo();
        chk("R10 decade chain closes after ten", q_dec, 4'h0);
        chk("R10 binary chain at ten", q_bin, 4'hA);
        for (int i = 0; i < 6; i++) pulse_lo();
        chk("R10 binary chain wraps at sixteen", q_bin, 4'h0);

        // R10: high-to-low chain, symmetric low bit in the decade variant.
        set_mode(2'd2);
        for (int i = 0; i < 5; i++) pulse_hi();
        chk("R10 bi-quinary low bit high after five", {3'b0, q_dec[0]}, 4'h1);
        for (int i = 0; i < 5; i++) pulse_hi();
        chk("R10 bi-quinary low bit low after ten", {3'b0, q_dec[0]}, 4'h0);

        // Random mix of pulses, loads, clears and wiring changes.
        for (int it = 0; it < 300; it++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r < 3) begin
                if (mode != 2'd2) pulse_lo(); else pulse_hi();
            end else if (r < 6) begin
                if (mode != 2'd1) pulse_hi(); else pulse_lo();
            end else if (r < 8) begin
                do_load(4'($urandom));
            end else if (r < 9) begin
                do_clear();
            end else begin
                set_mode(2'($urandom % 3));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule